// File: doc/BRIEF.md
# Power-Fail Detect and Restart Sequencer

This block sits between the supply status lines and the processor core. It takes two active-low status inputs: an early AC-low warning and a DC-low hard reset. From them it drives three outputs: a power-fail interrupt request, an internal buffered reset, and an enable for the master clock divider. Both raw inputs are first synchronized and filtered, so slow or bouncing edges turn into at most one clean transition.

While the processor is running, an assertion of AC-low raises the interrupt, and the processor keeps executing so software can get ready for shutdown. The same edge sets a power-fail latch. That latch fires a chain of two one-shot timers. The first gives software its grace period. The second forces the internal reset and stops the clock divider for a bounded time. While DC-low is asserted, the internal reset stays active, the latch is cleared and AC-low edges are ignored.

On power-up the block allows the processor to run only in the correct order. First DC-low must be released and stay released for a programmable settling time. After that, AC-low must be released.

Top module: `pfr_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the power-up order completes, sys_rst_o is 1, clk_en_o is 0 and pf_irq_o is 0.
- R2: A low pulse on either status input (0 = asserted) that lasts fewer than FILT_LEN clock cycles has no effect on any output.
- R3: When the processor is running (clk_en_o = 1) and AC-low asserts, pf_irq_o goes to 1. clk_en_o stays 1 and sys_rst_o stays 0 until the reset stage begins.
- R4: Once pf_irq_o is 1, it stays 1 until a one-cycle high pulse on irq_ack_i clears it, or until DC-low asserts.
- R5: Exactly OS1_CYC cycles after pf_irq_o rises, sys_rst_o goes to 1 and clk_en_o goes to 0. This lasts exactly OS2_CYC cycles. After that the clock resumes if DC-low is still released.
- R6: Once a power fail has been registered, further AC-low assertions raise no interrupt and start no new reset stage until DC-low has been asserted.
- R7: While DC-low is asserted, sys_rst_o is 1, clk_en_o is 0, pf_irq_o is 0 and AC-low edges are ignored. The power-fail record is cleared, so after the next power-up a new AC-low assertion raises the interrupt again.
- R8: clk_en_o becomes 1 on power-up only after two things, in this order: DC-low has been released continuously for STAB_CYC cycles, and then AC-low goes from asserted to released.
- R9: If AC-low is released before that DC settling window completes, the block stays held in reset until AC-low asserts and is released again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ac_low_ni | input | 1 | Raw AC-low warning, 0 = asserted |
| dc_low_ni | input | 1 | Raw DC-low reset, 0 = asserted |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse, active high |
| pf_irq_o | output | 1 | Power-fail interrupt request |
| sys_rst_o | output | 1 | Buffered internal reset, active high |
| clk_en_o | output | 1 | Master clock divider enable |

## Verification
The bench measures the gap from interrupt to reset and the width of the reset stage to the exact cycle. This catches a one-shot that is off by one or a chain that starts the second stage early. It tries both wrong power-up orders: AC-low released before DC-low, and AC-low released during the DC settling window. A sequencer that only looks at levels would start the clock in these cases. It fires bursts of short random glitches, which an unfiltered edge detector would turn into spurious interrupts. It also re-asserts AC-low while a power fail is still recorded, where a retriggerable latch or timer would stop the clock a second time.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    PW_OFF  = 2'd0,
    PW_STAB = 2'd1,
    PW_WAIT = 2'd2,
    PW_RUN  = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pfr_filt.sv
// Two-flop synchronizer plus persistence filter; raw_i active high.
module pfr_filt #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          flip;

  assign flip = (sync_q[1] != lvl_q) && (cnt_q == CW'(FILT_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      lvl_q  <= 1'b1;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      rise_o <= flip && !lvl_q;
      fall_o <= flip && lvl_q;
      if (sync_q[1] == lvl_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        cnt_q <= '0;
        lvl_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/pfr_oneshot.sv
// Non-retriggerable one-shot, busy for exactly DUR cycles.
module pfr_oneshot #(
  parameter int unsigned DUR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(DUR + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(DUR - 1);
    end
  end
endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
  import pfr_pkg::*;
#(
  parameter int unsigned STAB_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ac_rise_i,
  input  logic ac_fall_i,
  input  logic dc_lvl_i,
  input  logic irq_ack_i,
  output logic pf_set_o,
  output logic latch_o,
  output logic irq_o,
  output logic run_o
);
  localparam int unsigned CW = $clog2(STAB_CYC + 1);

  pw_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          latch_q, irq_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (dc_lvl_i) begin
      st_d  = PW_OFF;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PW_OFF: begin
          st_d  = PW_STAB;
          cnt_d = '0;
        end
        PW_STAB: begin
          if (cnt_q == CW'(STAB_CYC - 1)) st_d = PW_WAIT;
          else                            cnt_d = cnt_q + 1'b1;
        end
        // only a release edge seen after DC settled starts the core
        PW_WAIT: if (ac_fall_i) st_d = PW_RUN;
        PW_RUN:  st_d = PW_RUN;
        default: st_d = PW_OFF;
      endcase
    end
  end

  assign pf_set_o = (st_q == PW_RUN) && ac_rise_i && !latch_q && !dc_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PW_OFF;
      cnt_q   <= '0;
      latch_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (dc_lvl_i)      latch_q <= 1'b0;
      else if (pf_set_o) latch_q <= 1'b1;
      if (dc_lvl_i)       irq_q <= 1'b0;
      else if (pf_set_o)  irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign irq_o   = irq_q;
  assign run_o   = (st_q == PW_RUN);
endmodule

// File: rtl/pfr_seq.sv
module pfr_seq #(
  parameter int unsigned FILT_LEN = 4,
  parameter int unsigned STAB_CYC = 1000,
  parameter int unsigned OS1_CYC  = 40,
  parameter int unsigned OS2_CYC  = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ac_low_ni,
  input  logic dc_low_ni,
  input  logic irq_ack_i,
  output logic pf_irq_o,
  output logic sys_rst_o,
  output logic clk_en_o
);
  localparam int unsigned NIN = 2;  // index 0: AC-low, 1: DC-low

  logic [NIN-1:0] raw, lvl, rise, fall;
  logic           dc_lvl, ac_fall, pf_set, pf_latch, run;
  logic           os1_busy, os1_done, os2_busy, os2_done;
  logic           unused_sig;

  assign raw = {~dc_low_ni, ~ac_low_ni};

  for (genvar gi = 0; gi < NIN; gi++) begin : g_in
    pfr_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[gi]),
      .lvl_o  (lvl[gi]),
      .rise_o (rise[gi]),
      .fall_o (fall[gi])
    );
  end

  assign dc_lvl     = lvl[1];
  assign ac_fall    = fall[0];
  assign unused_sig = ^{lvl[0], rise[1], fall[1], os2_done};

  pfr_ctrl #(.STAB_CYC(STAB_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ac_rise_i (rise[0]),
    .ac_fall_i (ac_fall),
    .dc_lvl_i  (dc_lvl),
    .irq_ack_i (irq_ack_i),
    .pf_set_o  (pf_set),
    .latch_o   (pf_latch),
    .irq_o     (pf_irq_o),
    .run_o     (run)
  );

  pfr_oneshot #(.DUR(OS1_CYC)) u_os1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (pf_set),
    .busy_o (os1_busy),
    .done_o (os1_done)
  );

  pfr_oneshot #(.DUR(OS2_CYC)) u_os2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (os1_done),
    .busy_o (os2_busy),
    .done_o (os2_done)
  );

  assign sys_rst_o = !run || os2_busy;
  assign clk_en_o  = run && !os2_busy;
endmodule

// File: rtl/pfr_seq_chk.sv
module pfr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_ack_i,
  input logic pf_irq_o,
  input logic sys_rst_o,
  input logic clk_en_o,
  input logic dc_lvl,
  input logic ac_fall,
  input logic pf_latch,
  input logic os1_busy,
  input logic os2_busy
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (sys_rst_o && !clk_en_o && !pf_irq_o);
    end
  end

  // R4
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_irq_o && !irq_ack_i && !dc_lvl |=> pf_irq_o);

  // R3
  irq_when_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_irq_o) |-> $past(clk_en_o));

  // R7
  dc_clears_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_lvl |=> !pf_latch && !pf_irq_o);

  // R6
  stage_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({os1_busy, os2_busy}));

  // R5
  stage_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(os2_busy) |-> $fell(os1_busy));

  // R8
  start_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> ($fell(os2_busy) || $past(ac_fall)));
endmodule

bind pfr_seq pfr_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_ack_i (irq_ack_i),
  .pf_irq_o  (pf_irq_o),
  .sys_rst_o (sys_rst_o),
  .clk_en_o  (clk_en_o),
  .dc_lvl    (dc_lvl),
  .ac_fall   (ac_fall),
  .pf_latch  (pf_latch),
  .os1_busy  (os1_busy),
  .os2_busy  (os2_busy)
);

// File: tb/pfr_seq_tb_top.sv
`timescale 1ns/1ps
module pfr_seq_tb_top;
  localparam int FILT = 4;
  localparam int STAB = 200;
  localparam int OS1  = 37;
  localparam int OS2  = 53;
  localparam int LAT  = FILT + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ac_n = 1'b0;
  logic dc_n = 1'b0;
  logic ack = 1'b0;
  logic irq, srst, cen;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pfr_seq #(.FILT_LEN(FILT), .STAB_CYC(STAB), .OS1_CYC(OS1), .OS2_CYC(OS2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ac_low_ni(ac_n), .dc_low_ni(dc_n),
    .irq_ack_i(ack), .pf_irq_o(irq), .sys_rst_o(srst), .clk_en_o(cen)
  );

  // expected clock enable after a power-up attempt
  function automatic bit exp_run(int dc_stable, bit ac_release_after);
    return (dc_stable >= STAB) && ac_release_after;
  endfunction

  function automatic bit glitch_ok(int w);
    return w < FILT;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_down();
    ac_n = 1'b0; cyc(LAT + 10);
    dc_n = 1'b0; cyc(LAT + 5);
  endtask

  task automatic power_up();
    dc_n = 1'b1; cyc(LAT + STAB + 10);
    ac_n = 1'b1; cyc(LAT + 5);
  endtask

  task automatic measure_fail(string tag);
    int n = 0;
    int d = 0;
    int w = 0;
    bit en_ok = 1'b1;
    ac_n = 1'b0;
    while (!irq && n < LAT + 20) begin cyc(1); n++; end
    chk(irq, "R3", {tag, " irq raised"}, irq, 1);
    chk(cen && !srst, "R3", {tag, " clock runs at irq"}, cen, 1);
    while (!srst && d < OS1 + 20) begin
      if (!cen) en_ok = 1'b0;
      cyc(1); d++;
    end
    chk(en_ok, "R3", {tag, " clock kept during grace"}, en_ok, 1);
    chk(d == OS1, "R5", {tag, " irq to reset delay"}, d, OS1);
    while (srst && w < OS2 + 20) begin
      if (cen) en_ok = 1'b0;
      cyc(1); w++;
    end
    chk(w == OS2, "R5", {tag, " reset width"}, w, OS2);
    chk(en_ok, "R5", {tag, " clock stopped in reset"}, en_ok, 1);
    chk(cen, "R5", {tag, " clock resumes"}, cen, 1);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    cyc(3);
    // R1 reset state
    chk(srst, "R1", "sys_rst in reset", srst, 1);
    chk(!cen, "R1", "clk_en in reset", cen, 0);
    chk(!irq, "R1", "irq in reset", irq, 0);
    rst_n = 1'b1;
    cyc(20);
    chk(srst && !cen, "R1", "held after reset release", cen, 0);

    // R9 wrong order: AC released before DC
    ac_n = 1'b1; cyc(LAT + 5);
    dc_n = 1'b1; cyc(LAT + STAB + 20);
    chk(cen == exp_run(STAB + 20, 1'b0), "R9", "AC first stays held", cen, 0);
    ac_n = 1'b0; cyc(LAT + 5);
    ac_n = 1'b1; cyc(LAT + 5);
    chk(cen == exp_run(STAB + 20, 1'b1), "R9", "restart after AC cycle", cen, 1);

    // R8 AC released inside the DC settling window
    power_down();
    dc_n = 1'b1; cyc(STAB / 2);
    ac_n = 1'b1; cyc(LAT + STAB + 20);
    chk(cen == exp_run(STAB / 2, 1'b1), "R8", "early AC release ignored", cen, 0);
    ac_n = 1'b0; cyc(LAT + 5);
    ac_n = 1'b1; cyc(LAT + 5);
    chk(cen, "R8", "run after settled AC release", cen, 1);

    // R8 normal order
    power_down();
    chk(srst && !cen, "R7", "DC asserted holds reset", srst, 1);
    power_up();
    chk(cen && !srst, "R8", "normal power-up runs", cen, 1);

    // R2 random short glitches
    for (int i = 0; i < 24; i++) begin
      int w = 1 + ($urandom % (FILT - 1));
      bit on_dc = ($urandom % 3) == 0;
      if (on_dc) dc_n = 1'b0; else ac_n = 1'b0;
      cyc(w);
      dc_n = 1'b1; ac_n = 1'b1;
      cyc(10 + ($urandom % 20));
      if (glitch_ok(w)) begin
        chk(!irq && cen && !srst, "R2", $sformatf("glitch w=%0d dc=%0d", w, on_dc),
            {irq, cen, srst}, 3'b010);
      end
    end

    // R3 R5 power fail
    measure_fail("first");
    cyc(100);
    chk(irq, "R4", "irq held without ack", irq, 1);
    ack = 1'b1; cyc(1); ack = 1'b0;
    chk(!irq, "R4", "ack clears irq", irq, 1'b0);

    // R6 re-assertion while latched
    begin
      int seen = 0;
      ac_n = 1'b1; cyc(LAT + 5);
      ac_n = 1'b0;
      for (int i = 0; i < LAT + OS1 + OS2 + 20; i++) begin
        cyc(1);
        if (irq || srst) seen++;
      end
      chk(seen == 0, "R6", "no second fail while latched", seen, 0);
    end

    // R7 DC assert clears state; AC ignored meanwhile
    dc_n = 1'b0; cyc(LAT + 2);
    chk(srst && !cen, "R7", "DC assert stops clock", cen, 0);
    for (int i = 0; i < 4; i++) begin
      ac_n = ~ac_n; cyc(LAT + 5);
      chk(!irq, "R7", "AC edge under DC ignored", irq, 0);
    end
    ac_n = 1'b0; cyc(LAT);
    power_up();
    measure_fail("after clear");

    // random repeated fail/restart cycles
    for (int k = 0; k < 4; k++) begin
      int hold;
      power_down();
      power_up();
      measure_fail($sformatf("loop%0d", k));
      hold = $urandom % 50;
      ac_n = 1'b1; cyc(LAT + hold);
      chk(irq, "R4", "irq held across AC release", irq, 1);
      dc_n = 1'b0; ac_n = 1'b0; cyc(LAT + 2);
      chk(!irq, "R4", "DC assert clears irq", irq, 0);
      dc_n = 1'b1; cyc(5); dc_n = 1'b0; cyc(LAT);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule